// File: doc/BRIEF.md
# Static-Order Task Dispatcher with Soft-Error Re-execution

The dispatcher is the central controller of a multiprocessor array. Before work begins, a table is loaded with one entry per task: the processor the task is mapped to, how many predecessor tasks must complete before it may run, and a mask of the tasks that depend on it. The static order of tasks on one processor is ascending task index.

From then on the block consumes processor report packets (started, finished, soft error, restarted) and produces command packets, each naming a processor and the task it is to run. Each report updates both the task table and the processor state table. A processor that becomes free is given the earliest task in its list whose inputs are complete. If an earlier task is still waiting on data, a later ready task goes first. A soft error sends the affected task back for re-execution ahead of anything else on that processor, and its dependents stay blocked until it finishes cleanly. Dependents mapped to other processors never stall unrelated work there.

Top module: `tcu_sched`

## Requirements
- R1: After synchronous reset, `cmd_valid` is low, no task is loaded, every processor is free, and `rpt_ready` is high.
- R2: A free processor is sent the lowest-indexed task that is mapped to it, waiting, and has a predecessor count of zero.
- R3: A waiting task whose predecessor count is not zero is skipped, and a later ready task on the same processor is dispatched instead.
- R4: An accepted finished report (event code 1) decrements the predecessor count of every task in the finished task's dependent mask. A task with a count of zero becomes eligible for dispatch.
- R5: An accepted soft-error report (event code 2) frees the processor and returns the task to waiting with its re-execution flag set, without touching any dependent's count. The task is then re-dispatched with `cmd_redo`=1, ahead of other ready tasks on that processor.
- R6: A dependent of an errored task that is mapped to another processor does not block other ready tasks on that processor.
- R7: When several free processors have a candidate, at most one command is issued per cycle. The grant rotates round-robin and starts after the most recently granted processor.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command fields stay unchanged.
- R9: A processor holds at most one outstanding command. It is not offered another until an accepted finished or error report frees it.
- R10: A report is accepted only when it names the task's own processor and the task is in a matching state. Started (code 0) and restarted (code 3) need the task issued or running. Finished and error need it running. Any other report changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one task-table entry |
| cfg_task | input | TW | Task index being written |
| cfg_proc | input | PW | Processor the task is mapped to |
| cfg_npred | input | CW | Number of predecessors |
| cfg_succ | input | NTASK | Mask of dependent tasks |
| rpt_valid | input | 1 | Report packet valid |
| rpt_ready | output | 1 | Report accepted (always high) |
| rpt_proc | input | PW | Reporting processor |
| rpt_task | input | TW | Task the report concerns |
| rpt_event | input | 2 | 0 started, 1 finished, 2 soft error, 3 restarted |
| cmd_valid | output | 1 | Command packet valid |
| cmd_ready | input | 1 | Command taken by the network |
| cmd_proc | output | PW | Destination processor |
| cmd_task | output | TW | Task to execute |
| cmd_redo | output | 1 | Command is a re-execution after a soft error |

## Verification
The hardest state to reach from the ports combines three things at once. A task has errored. One of its dependents sits on a second processor that has become free. A third, unrelated task on that second processor is ready. Reaching it needs a precise interleaving of start, error, restart and finish reports against outstanding commands. The stimulus table scripts that interleaving report by report, so the unrelated task must appear in place of the blocked dependent. A second hard case is a finished report arriving before the command has even been taken. It is reached by holding `cmd_ready` low while the report is sent, then checking that no extra command follows.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    typedef enum logic [1:0] {
        EV_STARTED   = 2'd0,
        EV_FINISHED  = 2'd1,
        EV_ERROR     = 2'd2,
        EV_RESTARTED = 2'd3
    } rpt_event_e;

    typedef enum logic [1:0] {
        PS_FREE,
        PS_ASSIGNED,
        PS_BUSY
    } proc_state_e;

    typedef enum logic [2:0] {
        TS_EMPTY,
        TS_WAIT,
        TS_ISSUED,
        TS_RUN,
        TS_DONE
    } task_state_e;

    typedef struct packed {
        logic start;
        logic finish;
        logic error;
    } rpt_flags_t;

    function automatic rpt_flags_t decode_report(logic vld, rpt_event_e ev);
        rpt_flags_t f;
        f.start  = vld && (ev == EV_STARTED || ev == EV_RESTARTED);
        f.finish = vld && (ev == EV_FINISHED);
        f.error  = vld && (ev == EV_ERROR);
        return f;
    endfunction

endpackage

// File: rtl/tcu_rr_arb.sv
module tcu_rr_arb #(
    parameter int N = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          gnt_any,
    output logic [PW-1:0] gnt_idx,
    output logic [N-1:0]  grant
);

    logic [PW-1:0] ptr_q;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = ptr_q;
        for (int off = 0; off < N; off++) begin
            if (!gnt_any && req[(int'(ptr_q) + off) % N]) begin
                gnt_any = 1'b1;
                gnt_idx = PW'((int'(ptr_q) + off) % N);
            end
        end
        grant = gnt_any ? (N'(1) << gnt_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take && gnt_any) begin
            ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0));

endmodule

// File: rtl/tcu_proc_table.sv
module tcu_proc_table
    import tcu_pkg::*;
#(
    parameter int NPROC = 4,
    localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  rpt_flags_t       rpt_flags,
    input  logic             rpt_ok,
    input  logic [PW-1:0]    rpt_proc,
    input  logic             iss_valid,
    input  logic [PW-1:0]    iss_proc,
    output logic [NPROC-1:0] proc_free,
    output logic [NPROC-1:0] proc_assigned
);

    proc_state_e st_q [NPROC];

    for (genvar p = 0; p < NPROC; p++) begin : g_flags
        assign proc_free[p]     = (st_q[p] == PS_FREE);
        assign proc_assigned[p] = (st_q[p] == PS_ASSIGNED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPROC; p++) st_q[p] <= PS_FREE;
        end else begin
            if (rpt_ok) begin
                if (rpt_flags.start)
                    st_q[rpt_proc] <= PS_BUSY;
                else if (rpt_flags.finish || rpt_flags.error)
                    st_q[rpt_proc] <= PS_FREE;
            end
            if (iss_valid) st_q[iss_proc] <= PS_ASSIGNED;
        end
    end

    // a command may only go to a processor that is idle
    assert_issue_free_R9: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> proc_free[iss_proc]);

endmodule

// File: rtl/tcu_task_table.sv
module tcu_task_table
    import tcu_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NTASK = 16,
    localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int TW = (NTASK > 1) ? $clog2(NTASK) : 1,
    localparam int CW = $clog2(NTASK + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [TW-1:0]             cfg_task,
    input  logic [PW-1:0]             cfg_proc,
    input  logic [CW-1:0]             cfg_npred,
    input  logic [NTASK-1:0]          cfg_succ,
    input  rpt_flags_t                rpt_flags,
    input  logic [PW-1:0]             rpt_proc,
    input  logic [TW-1:0]             rpt_task,
    output logic                      rpt_ok,
    input  logic                      iss_valid,
    input  logic [TW-1:0]             iss_task,
    output logic [NPROC-1:0]          cand_valid,
    output logic [NPROC-1:0][TW-1:0]  cand_task,
    output logic [NPROC-1:0]          cand_redo
);

    task_state_e      st_q    [NTASK];
    logic [PW-1:0]    owner_q [NTASK];
    logic [CW-1:0]    pred_q  [NTASK];
    logic [NTASK-1:0] succ_q  [NTASK];
    logic [NTASK-1:0] redo_q;

    logic [NPROC-1:0][NTASK-1:0] elig;
    task_state_e cur_st;
    logic        own_ok;
    logic        fin_ok;

    // report acceptance: right owner and a state that matches the event
    always_comb begin
        cur_st = st_q[rpt_task];
        own_ok = (owner_q[rpt_task] == rpt_proc);
        rpt_ok = own_ok && (
                   (rpt_flags.start && (cur_st == TS_ISSUED || cur_st == TS_RUN)) ||
                   ((rpt_flags.finish || rpt_flags.error) && cur_st == TS_RUN));
        fin_ok = rpt_ok && rpt_flags.finish;
    end

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        for (genvar t = 0; t < NTASK; t++) begin : g_task
            assign elig[p][t] = (st_q[t] == TS_WAIT) && (owner_q[t] == PW'(p)) &&
                                (pred_q[t] == '0);
        end

        logic          pv;
        logic [TW-1:0] pt;
        logic          pr;

        // lowest index wins; a pending re-execution overrides the static pick
        always_comb begin
            pv = 1'b0;
            pt = '0;
            pr = 1'b0;
            for (int t = NTASK - 1; t >= 0; t--) begin
                if (elig[p][t]) begin
                    pv = 1'b1;
                    pt = TW'(t);
                end
            end
            for (int t = NTASK - 1; t >= 0; t--) begin
                if (elig[p][t] && redo_q[t]) begin
                    pt = TW'(t);
                    pr = 1'b1;
                end
            end
        end

        assign cand_valid[p] = pv;
        assign cand_task[p]  = pt;
        assign cand_redo[p]  = pr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NTASK; t++) begin
                st_q[t]    <= TS_EMPTY;
                owner_q[t] <= '0;
                pred_q[t]  <= '0;
                succ_q[t]  <= '0;
            end
            redo_q <= '0;
        end else begin
            if (fin_ok) begin
                for (int s = 0; s < NTASK; s++) begin
                    if (succ_q[rpt_task][s] && pred_q[s] != '0)
                        pred_q[s] <= pred_q[s] - 1'b1;
                end
            end
            if (rpt_ok) begin
                if (rpt_flags.start) begin
                    st_q[rpt_task]   <= TS_RUN;
                    redo_q[rpt_task] <= 1'b0;
                end else if (rpt_flags.finish) begin
                    st_q[rpt_task]   <= TS_DONE;
                end else if (rpt_flags.error) begin
                    st_q[rpt_task]   <= TS_WAIT;
                    redo_q[rpt_task] <= 1'b1;
                end
            end
            if (iss_valid) st_q[iss_task] <= TS_ISSUED;
            if (cfg_we) begin
                st_q[cfg_task]    <= TS_WAIT;
                owner_q[cfg_task] <= cfg_proc;
                pred_q[cfg_task]  <= cfg_npred;
                succ_q[cfg_task]  <= cfg_succ;
                redo_q[cfg_task]  <= 1'b0;
            end
        end
    end

    // dispatch chosen by the top must name a waiting task with all inputs in
    assert_issue_ready_R4: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (st_q[iss_task] == TS_WAIT && pred_q[iss_task] == '0));

    // an accepted error must leave the task waiting again
    assert_error_requeue_R5: assert property (@(posedge clk) disable iff (rst)
        (rpt_ok && rpt_flags.error && !cfg_we) |=> st_q[$past(rpt_task)] == TS_WAIT);

endmodule

// File: rtl/tcu_sched.sv
module tcu_sched
    import tcu_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NTASK = 16,
    localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int TW = (NTASK > 1) ? $clog2(NTASK) : 1,
    localparam int CW = $clog2(NTASK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [TW-1:0]    cfg_task,
    input  logic [PW-1:0]    cfg_proc,
    input  logic [CW-1:0]    cfg_npred,
    input  logic [NTASK-1:0] cfg_succ,
    input  logic             rpt_valid,
    output logic             rpt_ready,
    input  logic [PW-1:0]    rpt_proc,
    input  logic [TW-1:0]    rpt_task,
    input  logic [1:0]       rpt_event,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [PW-1:0]    cmd_proc,
    output logic [TW-1:0]    cmd_task,
    output logic             cmd_redo
);

    rpt_flags_t              flags;
    logic                    rpt_ok;
    logic [NPROC-1:0]        cand_valid;
    logic [NPROC-1:0][TW-1:0] cand_task;
    logic [NPROC-1:0]        cand_redo;
    logic [NPROC-1:0]        proc_free;
    logic [NPROC-1:0]        proc_assigned;
    logic [NPROC-1:0]        req;
    logic [NPROC-1:0]        grant;
    logic                    gnt_any;
    logic [PW-1:0]           gnt_idx;
    logic                    load;
    logic [TW-1:0]           iss_task;

    assign rpt_ready = 1'b1;
    assign flags     = decode_report(rpt_valid, rpt_event_e'(rpt_event));
    assign req       = proc_free & cand_valid;
    assign load      = gnt_any && (!cmd_valid || cmd_ready);
    assign iss_task  = cand_task[gnt_idx];

    tcu_task_table #(.NPROC(NPROC), .NTASK(NTASK)) u_tasks (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_task   (cfg_task),
        .cfg_proc   (cfg_proc),
        .cfg_npred  (cfg_npred),
        .cfg_succ   (cfg_succ),
        .rpt_flags  (flags),
        .rpt_proc   (rpt_proc),
        .rpt_task   (rpt_task),
        .rpt_ok     (rpt_ok),
        .iss_valid  (load),
        .iss_task   (iss_task),
        .cand_valid (cand_valid),
        .cand_task  (cand_task),
        .cand_redo  (cand_redo)
    );

    tcu_proc_table #(.NPROC(NPROC)) u_procs (
        .clk           (clk),
        .rst           (rst),
        .rpt_flags     (flags),
        .rpt_ok        (rpt_ok),
        .rpt_proc      (rpt_proc),
        .iss_valid     (load),
        .iss_proc      (gnt_idx),
        .proc_free     (proc_free),
        .proc_assigned (proc_assigned)
    );

    tcu_rr_arb #(.N(NPROC)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .take    (load),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx),
        .grant   (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_proc  <= '0;
            cmd_task  <= '0;
            cmd_redo  <= 1'b0;
        end else if (load) begin
            cmd_valid <= 1'b1;
            cmd_proc  <= gnt_idx;
            cmd_task  <= iss_task;
            cmd_redo  <= cand_redo[gnt_idx];
        end else if (cmd_ready) begin
            cmd_valid <= 1'b0;
        end
    end

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_proc) && $stable(cmd_task) && $stable(cmd_redo)));

    assert_cmd_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> proc_assigned[cmd_proc]);

    assert_grant_matches_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> grant[gnt_idx]);

endmodule

// File: tb/tcu_sched_bench.sv
module tcu_sched_bench;

    localparam int NPROC = 4;
    localparam int NTASK = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_task;
    logic [1:0]  cfg_proc;
    logic [4:0]  cfg_npred;
    logic [15:0] cfg_succ;
    logic        rpt_valid;
    logic        rpt_ready;
    logic [1:0]  rpt_proc;
    logic [3:0]  rpt_task;
    logic [1:0]  rpt_event;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_proc;
    logic [3:0]  cmd_task;
    logic        cmd_redo;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tcu_sched #(.NPROC(NPROC), .NTASK(NTASK)) u_tcu_sched (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_proc(cfg_proc),
        .cfg_npred(cfg_npred), .cfg_succ(cfg_succ),
        .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_proc(rpt_proc),
        .rpt_task(rpt_task), .rpt_event(rpt_event),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_proc(cmd_proc),
        .cmd_task(cmd_task), .cmd_redo(cmd_redo)
    );

    // kind(1: expect command, 0: report) proc(2) task(4) code(2: event, or redo in bit 0)
    localparam int NV = 21;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 2'd0, 4'd0, 2'd0},  // R2 first task on p0
        {1'b1, 2'd1, 4'd3, 2'd0},  // R7 next processor
        {1'b1, 2'd2, 4'd7, 2'd0},  // R3 t6 not ready, t7 goes
        {1'b0, 2'd0, 4'd0, 2'd0},
        {1'b0, 2'd0, 4'd0, 2'd2},  // soft error on t0
        {1'b1, 2'd0, 4'd0, 2'd1},  // R5 redo ahead of t1
        {1'b0, 2'd0, 4'd0, 2'd3},
        {1'b0, 2'd1, 4'd3, 2'd0},
        {1'b0, 2'd1, 4'd3, 2'd1},
        {1'b1, 2'd1, 4'd5, 2'd0},  // R6 t4 blocked by errored t0, t5 runs
        {1'b0, 2'd2, 4'd7, 2'd0},
        {1'b0, 2'd2, 4'd7, 2'd1},
        {1'b1, 2'd2, 4'd6, 2'd0},  // R4 released by t3
        {1'b0, 2'd0, 4'd0, 2'd1},
        {1'b1, 2'd0, 4'd1, 2'd0},  // R2 static order t1 before t2
        {1'b0, 2'd1, 4'd5, 2'd0},
        {1'b0, 2'd1, 4'd5, 2'd1},
        {1'b1, 2'd1, 4'd4, 2'd0},  // R4 released by t0
        {1'b0, 2'd0, 4'd1, 2'd0},
        {1'b0, 2'd0, 4'd1, 2'd1},
        {1'b1, 2'd0, 4'd2, 2'd0}   // R9 p0 freed only by finish
    };

    task automatic check(input bit ok, input string req, input string msg);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_we = 0; rpt_valid = 0; cmd_ready = 0;
        cfg_task = 0; cfg_proc = 0; cfg_npred = 0; cfg_succ = 0;
        rpt_proc = 0; rpt_task = 0; rpt_event = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input int t, input int p, input int np, input logic [15:0] sm);
        cfg_we = 1; cfg_task = 4'(t); cfg_proc = 2'(p); cfg_npred = 5'(np); cfg_succ = sm;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic report(input int p, input int t, input int ev);
        rpt_valid = 1; rpt_proc = 2'(p); rpt_task = 4'(t); rpt_event = 2'(ev);
        @(negedge clk);
        rpt_valid = 0;
    endtask

    // waits up to maxw negedges for a command, compares it, lets it be taken
    task automatic expect_cmd(input int p, input int t, input bit rd, input int maxw,
                              input string req);
        int w = 0;
        while (!cmd_valid && w < maxw) begin
            @(negedge clk);
            w++;
        end
        check(cmd_valid && cmd_proc == 2'(p) && cmd_task == 4'(t) && cmd_redo == rd, req,
              $sformatf("cmd v=%0b p=%0d t=%0d r=%0b, expected p=%0d t=%0d r=%0b",
                        cmd_valid, cmd_proc, cmd_task, cmd_redo, p, t, rd));
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run hung, got %0d cycles, expected under 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        check(cmd_valid == 0, "R1", $sformatf("cmd_valid=%0b expected 0", cmd_valid));
        check(rpt_ready == 1, "R1", $sformatf("rpt_ready=%0b expected 1", rpt_ready));
        repeat (3) @(negedge clk);
        check(cmd_valid == 0, "R1", "no table loaded yet, expected no command");

        // main scenario: p0 t0,t1,t2  p1 t3,t4,t5  p2 t6,t7
        load(0, 0, 0, 16'h0014);
        load(1, 0, 0, 16'h0000);
        load(2, 0, 1, 16'h0000);
        load(3, 1, 0, 16'h0040);
        load(4, 1, 1, 16'h0000);
        load(5, 1, 0, 16'h0000);
        load(6, 2, 1, 16'h0000);
        load(7, 2, 0, 16'h0000);
        begin
            logic [1:0] p0;
            logic [3:0] t0;
            p0 = cmd_proc; t0 = cmd_task;
            repeat (2) @(negedge clk);
            check(cmd_valid && cmd_proc == p0 && cmd_task == t0, "R8",
                  $sformatf("held cmd p=%0d t=%0d, expected p=%0d t=%0d", cmd_proc, cmd_task, p0, t0));
        end
        cmd_ready = 1;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][8])
                expect_cmd(int'(VEC[i][7:6]), int'(VEC[i][5:2]), VEC[i][0], 30,
                           $sformatf("vector %0d", i));
            else
                report(int'(VEC[i][7:6]), int'(VEC[i][5:2]), int'(VEC[i][1:0]));
        end
        repeat (10) @(negedge clk);
        check(cmd_valid == 0, "R9", "all processors occupied or idle-empty, expected no command");

        // R10: finished report on a task not yet running is ignored
        do_reset();
        load(9, 3, 0, 16'h0100);
        load(8, 3, 1, 16'h0000);
        repeat (2) @(negedge clk);
        report(3, 9, 1);
        cmd_ready = 1;
        expect_cmd(3, 9, 0, 0, "R10 issued command");
        repeat (6) @(negedge clk);
        check(cmd_valid == 0, "R10", $sformatf("cmd_valid=%0b t=%0d, expected none", cmd_valid, cmd_task));
        report(3, 9, 0);
        report(3, 9, 1);
        expect_cmd(3, 8, 0, 10, "R4 after accepted finish");

        // R7: rotation starts after the last granted processor
        do_reset();
        load(10, 1, 0, 16'h0000);
        load(11, 2, 0, 16'h0000);
        load(12, 0, 0, 16'h0000);
        repeat (2) @(negedge clk);
        cmd_ready = 1;
        expect_cmd(1, 10, 0, 0, "R7 first");
        expect_cmd(2, 11, 0, 0, "R7 second, next cycle");
        expect_cmd(0, 12, 0, 0, "R7 wraps, next cycle");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule